// File: doc/BRIEF.md
# Oversampled Stream Bit Aligner

This block sits behind a deserializer lane that carries data sent with every bit repeated three times. The deserializer hands over 10-bit words at an arbitrary bit phase. The aligner works out where each run of three identical samples starts. It keeps a window made of the present word, the previous word and one older bit, and a barrel shifter picks a 10-bit slice of that window at a candidate offset. A free-running modulo-3 word counter fixes a fixed 30-bit grid over the shifted stream. Every level change inside the slice, and between its first bit and the bit just before it, has to land on a triplet boundary of that grid.

While searching, each word that breaks the rule moves the shifter to the next candidate offset. A long enough clean run declares lock and freezes the offset. While locked, three consecutive shifted words are packed into one 30-bit word, which is flagged with a single-cycle valid strobe. A run of rule-breaking words drops lock, and the search continues from the next offset. A downstream downsampler can then take one sample out of every triplet.

Top module: `triplet_aligner`

## Requirements
- R1: While reset is asserted, `alignLock` and `grpValid` are 0 and `grpData` is all zeros.
- R2: A word is clean only if every level change, counting the one from the preceding stream bit, falls on a triplet boundary of the grid. A stream that toggles on every bit (each word `10'b1010101010`) never gives lock and never gives a valid strobe.
- R3: Lock is declared on the edge that sees the eighth consecutive clean word. On an all-zero stream after reset, `alignLock` is still 0 after the seventh clock edge and is 1 after the eighth.
- R4: A stream of repeated triplets is locked within 60 cycles of reset for each of the three possible triplet phases. The shifter offset always stays below 3.
- R5: Bit 0 of `grpData` is the earliest received stream bit, and bit 0 of `rxWord` is the earliest bit of its word. Each 3-bit field [3t+2:3t] of a locked group holds three equal bits. Taking bit 3t of each field, for t = 0 to 9, gives ten consecutive transmitted data bits, and consecutive groups continue the sequence.
- R6: `grpValid` is a one-cycle pulse that occurs exactly every 3 cycles while locked, and never while `alignLock` is 0.
- R7: While locked, the offset is frozen. Up to two consecutive corrupted input words do not clear `alignLock`, and the groups that follow decode on the same grid.
- R8: Lock drops on the fourth consecutive rule-breaking word. When input words n to n+5 all carry `10'b1010101010`, `alignLock` is still 1 after the edge that takes word n+2 and is 0 after the edge that takes word n+4.
- R9: After lock is lost, the search resumes. When a one-bit slip shifts the triplet phase, lock is lost, regained on the new phase, and groups decode correctly again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock of the lane |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxWord | input | 10 | Unaligned word from the deserializer; bit 0 is the earliest bit |
| alignLock | output | 1 | High while the offset is locked |
| grpData | output | 30 | Three aligned words; bit 0 is the earliest bit |
| grpValid | output | 1 | One-cycle strobe marking a new `grpData` |

## Verification
The bench drives `rxWord` on the falling edge and reads the outputs on the next falling edge. A word presented at edge k therefore affects the lock counters at edge k, and `alignLock` is read half a cycle later.

Lock on a clean zero stream is due at the eighth edge after reset. Loss of lock after a six-word corruption is due between the edges that take words n+3 and n+4, so the bench samples after n+2 (still locked) and after n+4 (dropped), which holds whatever the offset.

Group strobes are due every third cycle, and the bench measures the spacing between them in falling edges. Group contents are checked against the transmitted sequence only after the corrupted words have fully passed through the window.

// File: rtl/ta_pkg.sv
package ta_pkg;

  // Width of the offset and phase fields; covers oversampling factors up to 16
  localparam int SEL_W = 4;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } alignState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [SEL_W-1:0] offset;    // barrel shifter select
    logic [SEL_W-1:0] phase;     // word position inside the 30-bit grid
    logic             packEn;    // store this aligned word into the group
    logic             packDone;  // this word completes the group
  } alignCtrl_t;

endpackage

// File: rtl/ta_datapath.sv
module ta_datapath
  import ta_pkg::*;
#(
  parameter int W   = 10,
  parameter int OVS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         rxWord,
  input  alignCtrl_t           ctrl,
  output logic                 wordGood,
  output logic [W*OVS-1:0]     grpData,
  output logic                 grpValid
);

  localparam int WIN_W = 2 * W + 1;
  localparam int GRP_W = W * OVS;

  logic [W-1:0]     prevWord;
  logic             prevLast;
  logic [WIN_W-1:0] window;
  logic [W-1:0]     cand    [OVS];
  logic             candPre [OVS];
  logic [W-1:0]     aligned;
  logic             preBit;
  logic [W-1:0]     trans;
  logic [W-1:0]     allowed;
  logic [W-1:0]     slot    [OVS-1];
  logic [GRP_W-1:0] assembled;

  // Oldest bit sits at index 0 of the window
  assign window = {rxWord, prevWord, prevLast};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevWord <= '0;
      prevLast <= 1'b0;
    end else begin
      prevWord <= rxWord;
      prevLast <= prevWord[W-1];
    end
  end

  // One slice per candidate offset
  for (genvar c = 0; c < OVS; c++) begin : g_cand
    assign cand[c]    = window[c+1 +: W];
    assign candPre[c] = window[c];
  end

  always_comb begin
    aligned = '0;
    preBit  = 1'b0;
    for (int c = 0; c < OVS; c++) begin
      if (ctrl.offset == SEL_W'(c)) begin
        aligned = cand[c];
        preBit  = candPre[c];
      end
    end
  end

  // Level changes, including the one from the bit before the slice
  assign trans = aligned ^ {aligned[W-2:0], preBit};

  always_comb begin
    for (int j = 0; j < W; j++) begin
      allowed[j] = (((int'(ctrl.phase) * W) + j) % OVS) == 0;
    end
  end

  assign wordGood = ~|(trans & ~allowed);

  // Group assembly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < OVS - 1; s++) slot[s] <= '0;
    end else begin
      for (int s = 0; s < OVS - 1; s++) begin
        if (ctrl.packEn && ctrl.phase == SEL_W'(s)) slot[s] <= aligned;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < OVS - 1; s++) assembled[s*W +: W] = slot[s];
    assembled[(OVS-1)*W +: W] = aligned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grpData  <= '0;
      grpValid <= 1'b0;
    end else begin
      grpValid <= ctrl.packDone;
      if (ctrl.packDone) grpData <= assembled;
    end
  end

  // R4
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.offset < SEL_W'(OVS));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grpValid |=> !grpValid);

endmodule

// File: rtl/ta_control.sv
module ta_control
  import ta_pkg::*;
#(
  parameter int OVS        = 3,
  parameter int LOCK_WORDS = 8,
  parameter int LOSE_WORDS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wordGood,
  output alignCtrl_t ctrl,
  output logic       locked
);

  localparam int GC_W = $clog2(LOCK_WORDS + 1);
  localparam int BC_W = $clog2(LOSE_WORDS + 1);

  alignState_t      state;
  logic [SEL_W-1:0] phase;
  logic [SEL_W-1:0] offset;
  logic [GC_W-1:0]  goodCnt;
  logic [BC_W-1:0]  badCnt;
  logic             armed;
  logic             lastPhase;
  logic [SEL_W-1:0] nextOfs;
  logic             gainNow;
  logic             dropNow;
  logic             packEn;

  assign lastPhase = (phase == SEL_W'(OVS - 1));
  assign nextOfs   = (offset == SEL_W'(OVS - 1)) ? '0 : offset + 1'b1;
  assign gainNow   = (state == ST_HUNT) && wordGood && (goodCnt == GC_W'(LOCK_WORDS - 1));
  assign dropNow   = (state == ST_LOCK) && !wordGood && (badCnt == BC_W'(LOSE_WORDS - 1));
  assign packEn    = (state == ST_LOCK) && !dropNow && (armed || phase == '0);

  assign ctrl.offset   = offset;
  assign ctrl.phase    = phase;
  assign ctrl.packEn   = packEn;
  assign ctrl.packDone = packEn && lastPhase;
  assign locked        = (state == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else begin
      phase <= lastPhase ? '0 : phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      offset  <= '0;
      goodCnt <= '0;
      badCnt  <= '0;
      armed   <= 1'b0;
    end else begin
      case (state)
        ST_HUNT: begin
          if (!wordGood) begin
            goodCnt <= '0;
            offset  <= nextOfs;
          end else if (gainNow) begin
            state   <= ST_LOCK;
            goodCnt <= '0;
            badCnt  <= '0;
            armed   <= 1'b0;
          end else begin
            goodCnt <= goodCnt + 1'b1;
          end
        end
        ST_LOCK: begin
          if (dropNow) begin
            state   <= ST_HUNT;
            offset  <= nextOfs;
            badCnt  <= '0;
            goodCnt <= '0;
            armed   <= 1'b0;
          end else begin
            if (wordGood) badCnt <= '0;
            else          badCnt <= badCnt + 1'b1;
            if (phase == '0) armed <= 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R3
  lock_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(goodCnt) == GC_W'(LOCK_WORDS - 1)) && $past(wordGood));

  // R7
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(offset));

  // R8
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(badCnt) == BC_W'(LOSE_WORDS - 1)) && !$past(wordGood));

endmodule

// File: rtl/triplet_aligner.sv
module triplet_aligner
  import ta_pkg::*;
#(
  parameter int WORD_W     = 10,
  parameter int OVS        = 3,
  parameter int LOCK_WORDS = 8,
  parameter int LOSE_WORDS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WORD_W-1:0]     rxWord,
  output logic                  alignLock,
  output logic [WORD_W*OVS-1:0] grpData,
  output logic                  grpValid
);

  alignCtrl_t ctrl;
  logic       wordGood;

  ta_control #(
    .OVS        (OVS),
    .LOCK_WORDS (LOCK_WORDS),
    .LOSE_WORDS (LOSE_WORDS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wordGood (wordGood),
    .ctrl     (ctrl),
    .locked   (alignLock)
  );

  ta_datapath #(
    .W   (WORD_W),
    .OVS (OVS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxWord   (rxWord),
    .ctrl     (ctrl),
    .wordGood (wordGood),
    .grpData  (grpData),
    .grpValid (grpValid)
  );

  // R6
  valid_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grpValid |-> alignLock);

endmodule

// File: tb/sim_triplet_aligner.sv
`timescale 1ns/1ps
module sim_triplet_aligner;
  localparam int W   = 10;
  localparam int OVS = 3;
  localparam int GW  = W * OVS;
  localparam logic [W-1:0] ALT = 10'b1010101010;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  rxWord = '0;
  logic          alignLock;
  logic [GW-1:0] grpData;
  logic          grpValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit prbs [127];
  int dataIdx = 0;
  int rep = 0;
  int mode = 0;          // 0 zeros, 1 toggling, 2 triplet data
  int corruptLeft = 0;
  bit slipReq = 1'b0;
  bit sawBadValid = 1'b0;

  always #2.5 clk = ~clk;

  triplet_aligner u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxWord    (rxWord),
    .alignLock (alignLock),
    .grpData   (grpData),
    .grpValid  (grpValid)
  );

  function automatic bit nextBit();
    bit b;
    b = prbs[dataIdx];
    rep = rep + 1;
    if (rep == OVS) begin
      rep = 0;
      dataIdx = (dataIdx + 1) % 127;
    end
    return b;
  endfunction

  // Driver and watchdog on the falling edge
  always @(negedge clk) begin : drv
    logic [W-1:0] wd;
    cycles = cycles + 1;
    if (grpValid && !alignLock) sawBadValid = 1'b1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
    wd = '0;
    if (mode == 0) begin
      rxWord <= '0;
    end else if (mode == 1) begin
      rxWord <= ALT;
    end else begin
      if (slipReq) begin
        void'(nextBit());
        slipReq = 1'b0;
      end
      for (int i = 0; i < W; i++) wd[i] = nextBit();
      if (corruptLeft > 0) begin
        corruptLeft = corruptLeft - 1;
        rxWord <= ALT;
      end else begin
        rxWord <= wd;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic resetDut(input int m, input int ph);
    @(posedge clk);
    rst_n = 1'b0;
    mode = m;
    dataIdx = 0;
    rep = ph;
    corruptLeft = 0;
    slipReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(alignLock == 1'b0, "R1", "lock in reset", alignLock, 0);
    chk(grpValid == 1'b0, "R1", "valid in reset", grpValid, 0);
    chk(grpData == '0, "R1", "data in reset", grpData, 0);
    rst_n = 1'b1;
  endtask

  task automatic waitLock(input int limit, input bit want, output bit got);
    got = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (alignLock == want) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic checkGroups(input int n, input string req);
    bit have = 1'b0;
    int pos = 0;
    for (int g = 0; g < n; g++) begin
      int waited = 0;
      bit ok;
      bit found;
      logic [W-1:0] dec;
      logic [W-1:0] exp;
      do begin
        @(negedge clk);
        waited++;
      end while (!grpValid && waited < 20);
      chk(grpValid, req, "group strobe seen", grpValid, 1);
      if (g > 0) chk(waited == 3, "R6", "strobe spacing", waited, 3);
      ok = 1'b1;
      for (int t = 0; t < W; t++) begin
        if (grpData[3*t] != grpData[3*t+1] || grpData[3*t] != grpData[3*t+2]) ok = 1'b0;
        dec[t] = grpData[3*t];
      end
      chk(ok, "R5", "triplet fields uniform", grpData, 0);
      if (!have) begin
        found = 1'b0;
        for (int p = 0; p < 127; p++) begin
          bit m = 1'b1;
          for (int t = 0; t < W; t++) if (prbs[(p + t) % 127] != dec[t]) m = 1'b0;
          if (m && !found) begin
            found = 1'b1;
            pos = (p + W) % 127;
          end
        end
        chk(found, req, "group found in data sequence", dec, 0);
        have = 1'b1;
      end else begin
        for (int t = 0; t < W; t++) exp[t] = prbs[(pos + t) % 127];
        chk(dec == exp, req, "group continues data sequence", dec, exp);
        pos = (pos + W) % 127;
      end
    end
  endtask

  task automatic testZeroLock();
    resetDut(0, 0);
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk(alignLock == 1'b0, "R3", "lock after 7 edges", alignLock, 0);
    @(posedge clk);
    @(negedge clk);
    chk(alignLock == 1'b1, "R3", "lock after 8 edges", alignLock, 1);
  endtask

  task automatic testNoLock();
    bit rose = 1'b0;
    bit anyValid = 1'b0;
    resetDut(1, 0);
    repeat (120) begin
      @(negedge clk);
      if (alignLock) rose = 1'b1;
      if (grpValid) anyValid = 1'b1;
    end
    chk(!rose, "R2", "no lock on toggling stream", rose, 0);
    chk(!anyValid, "R2", "no strobe on toggling stream", anyValid, 0);
  endtask

  task automatic testPhase(input int ph);
    bit got;
    resetDut(2, ph);
    waitLock(60, 1'b1, got);
    chk(got, "R4", $sformatf("lock on phase %0d", ph), got, 1);
    checkGroups(5, "R5");
  endtask

  task automatic testHold();
    @(posedge clk);
    corruptLeft = 2;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(alignLock == 1'b1, "R7", "lock held over short glitch", alignLock, 1);
    end
    repeat (6) @(negedge clk);
    checkGroups(4, "R7");
  endtask

  task automatic testDrop();
    bit got;
    @(posedge clk);
    corruptLeft = 6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(alignLock == 1'b1, "R8", "lock after word n+2", alignLock, 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(alignLock == 1'b0, "R8", "lock after word n+4", alignLock, 0);
    waitLock(80, 1'b1, got);
    chk(got, "R9", "relock after corruption", got, 1);
    checkGroups(3, "R9");
  endtask

  task automatic testSlip();
    bit got;
    @(posedge clk);
    slipReq = 1'b1;
    waitLock(200, 1'b0, got);
    chk(got, "R9", "lock lost after slip", got, 1);
    waitLock(80, 1'b1, got);
    chk(got, "R9", "lock regained after slip", got, 1);
    checkGroups(4, "R9");
  endtask

  initial begin
    logic [6:0] s;
    s = 7'h7F;
    for (int i = 0; i < 127; i++) begin
      bit b;
      b = s[6] ^ s[5];
      prbs[i] = b;
      s = {s[5:0], b};
    end
    testZeroLock();
    testNoLock();
    testPhase(0);
    testPhase(2);
    testPhase(1);
    testHold();
    testDrop();
    testSlip();
    chk(!sawBadValid, "R6", "strobe never while unlocked", sawBadValid, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

endmodule